// File: doc/BRIEF.md
# Zero-Gated Output-Stationary Processing Element

This block is one cell of an output-stationary systolic mesh. Each enabled cycle it registers the incoming weight, activation and tile-switch flag and passes them on to its neighbours. It also adds the signed product of the weight and the activation into a local accumulator. When either operand is zero the accumulator is not written, which saves the switching energy of a useless add.

A second register, called the reserve, sits on the row's scan chain. Data shifts through it from the right-hand neighbour to the left-hand one while the multiply-add keeps running. When a tile-switch flag arrives, the accumulator and the reserve trade contents in a single cycle. The finished sum moves into the reserve, where it can be drained. A preloaded starting value moves into the accumulator, and the product of that cycle is added on top of it. No cycle is lost at a tile boundary.

A single pipeline enable stalls the whole mesh. There is no per-link valid/ready handshake: when enable is low, every register in the cell holds its value, and upstream logic must hold its data until enable returns. The scan, operand and flag pins are all plain data pins that are qualified by this enable.

Top module: `pe_zg_cell`

## Requirements
- R1: After reset, all forwarded outputs and the reserve register are zero, and the accumulator is zero.
- R2: On an enabled cycle, `w_out`, `a_out` and `sw_out` take the values of `w_in`, `a_in` and `sw_in`, one cycle later.
- R3: On an enabled cycle with `sw_in` low and both operands non-zero, the accumulator becomes the accumulator plus the two's-complement signed product `w_in * a_in`.
- R4: On an enabled cycle with `sw_in` low and an operand equal to zero, the accumulator is not written and keeps its value.
- R5: On an enabled cycle with `sw_in` high, the reserve takes the old accumulator value. In the same cycle the accumulator takes the old reserve value plus the current product.
- R6: On an enabled cycle with `scan_en` high and `sw_in` low, the reserve loads `scan_in`. `scan_out` always shows the reserve.
- R7: When `sw_in` and `scan_en` are both high, the swap wins and `scan_in` is ignored that cycle.
- R8: With `en` low, no register of the cell changes, whatever the other inputs do.
- R9: Scan shifting and accumulation act in the same enabled cycle, without either stalling the other.
- R10: The accumulator is 2*OPW+GUARD bits wide and wraps modulo 2^(2*OPW+GUARD) on overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Pipeline enable; low freezes every register |
| scan_en | input | 1 | Shift the reserve register along the scan chain |
| w_in | input | OPW | Signed weight from the cell above |
| a_in | input | OPW | Signed activation from the cell to the left |
| sw_in | input | 1 | Tile-switch flag travelling with the weight |
| scan_in | input | ACCW | Scan data from the cell to the right |
| w_out | output | OPW | Registered weight to the cell below |
| a_out | output | OPW | Registered activation to the cell to the right |
| sw_out | output | 1 | Registered tile-switch flag to the cell below |
| scan_out | output | ACCW | Reserve register contents, to the cell to the left |

## Verification
The assertions check, on every cycle, the following properties. Operands are forwarded correctly. A zero operand leaves the accumulator untouched. A non-zero product is added. A swap moves the accumulator into the reserve. A scan shift loads the reserve from the right-hand neighbour. A low enable freezes all outputs. The accumulator is not a port, so its contents can only be seen through the bench's scenarios. Those scenarios do the following:
- preload a value;
- swap it in;
- accumulate across zero and non-zero operands, and across an overflow;
- swap again to drain the sum through `scan_out`;
- check that a shift requested in a swap cycle is discarded.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SWAP = 2'd2
  } acc_op_e;

  typedef enum logic [1:0] {
    RSV_HOLD  = 2'd0,
    RSV_SHIFT = 2'd1,
    RSV_TAKE  = 2'd2
  } rsv_op_e;
endpackage

// File: rtl/pe_fwd_regs.sv
module pe_fwd_regs #(
  parameter int OPW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [OPW-1:0] w_in,
  input  logic signed [OPW-1:0] a_in,
  input  logic                  sw_in,
  output logic signed [OPW-1:0] w_out,
  output logic signed [OPW-1:0] a_out,
  output logic                  sw_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_out  <= '0;
      a_out  <= '0;
      sw_out <= 1'b0;
    end else if (en) begin
      w_out  <= w_in;
      a_out  <= a_in;
      sw_out <= sw_in;
    end
  end

  // R2: enabled cycles forward all three operands
  p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (w_out == $past(w_in)) && (a_out == $past(a_in)) && (sw_out == $past(sw_in)));

  // R8: a stall holds the forwarding registers
  p_fwd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(w_out) && $stable(a_out) && $stable(sw_out));
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic                  en,
  input  logic                  scan_en,
  input  logic                  sw_in,
  input  logic signed [OPW-1:0] w_in,
  input  logic signed [OPW-1:0] a_in,
  output acc_op_e               acc_op,
  output rsv_op_e               rsv_op
);
  logic operand_zero;

  assign operand_zero = (w_in == '0) || (a_in == '0);

  always_comb begin
    acc_op = ACC_HOLD;
    rsv_op = RSV_HOLD;
    if (en) begin
      if (sw_in) begin
        // the swap has priority over any scan request
        acc_op = ACC_SWAP;
        rsv_op = RSV_TAKE;
      end else begin
        if (!operand_zero) acc_op = ACC_ADD;
        if (scan_en)       rsv_op = RSV_SHIFT;
      end
    end
  end
endmodule

// File: rtl/pe_mac.sv
module pe_mac
  import pe_pkg::*;
#(
  parameter int OPW   = 8,
  parameter int GUARD = 4,
  localparam int PW   = 2 * OPW,
  localparam int ACCW = PW + GUARD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  sw_in,
  input  acc_op_e               acc_op,
  input  logic signed [OPW-1:0] w_in,
  input  logic signed [OPW-1:0] a_in,
  input  logic [ACCW-1:0]       rsv_q,
  output logic [ACCW-1:0]       acc_q
);
  logic signed [PW-1:0] prod;
  logic [ACCW-1:0]      prod_ext;

  assign prod     = w_in * a_in;
  assign prod_ext = {{GUARD{prod[PW-1]}}, prod};

  // additions truncate to ACCW bits, giving wrap-around
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      unique case (acc_op)
        ACC_ADD:  acc_q <= acc_q + prod_ext;
        ACC_SWAP: acc_q <= rsv_q + prod_ext;
        default:  acc_q <= acc_q;
      endcase
    end
  end

  // R4: a zero operand leaves the accumulator untouched
  p_zero_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sw_in && ((w_in == '0) || (a_in == '0))) |=> $stable(acc_q));

  // R3 / R10: a non-zero product is added modulo 2^ACCW
  p_mac_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sw_in && (w_in != '0) && (a_in != '0)) |=>
      (acc_q == ACCW'($past(acc_q) + $past(prod_ext))));

  // R8: a stall holds the accumulator
  p_acc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/pe_reserve.sv
module pe_reserve
  import pe_pkg::*;
#(
  parameter int ACCW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            sw_in,
  input  logic            scan_en,
  input  rsv_op_e         rsv_op,
  input  logic [ACCW-1:0] scan_in,
  input  logic [ACCW-1:0] acc_q,
  output logic [ACCW-1:0] rsv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_q <= '0;
    end else begin
      unique case (rsv_op)
        RSV_SHIFT: rsv_q <= scan_in;
        RSV_TAKE:  rsv_q <= acc_q;
        default:   rsv_q <= rsv_q;
      endcase
    end
  end

  // R5 / R7: a swap moves the accumulator into the reserve, even with scan_en high
  p_swap_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sw_in) |=> (rsv_q == $past(acc_q)));

  // R6: a scan shift loads the value from the right-hand neighbour
  p_scan_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scan_en && !sw_in) |=> (rsv_q == $past(scan_in)));

  // R8: a stall holds the reserve
  p_rsv_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rsv_q));
endmodule

// File: rtl/pe_zg_cell.sv
module pe_zg_cell
  import pe_pkg::*;
#(
  parameter int OPW   = 8,
  parameter int GUARD = 4,
  localparam int ACCW = 2 * OPW + GUARD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  scan_en,
  input  logic signed [OPW-1:0] w_in,
  input  logic signed [OPW-1:0] a_in,
  input  logic                  sw_in,
  input  logic [ACCW-1:0]       scan_in,
  output logic signed [OPW-1:0] w_out,
  output logic signed [OPW-1:0] a_out,
  output logic                  sw_out,
  output logic [ACCW-1:0]       scan_out
);
  acc_op_e         acc_op;
  rsv_op_e         rsv_op;
  logic [ACCW-1:0] acc_q;
  logic [ACCW-1:0] rsv_q;

  pe_fwd_regs #(.OPW(OPW)) u_fwd (
    .clk(clk), .rst_n(rst_n), .en(en),
    .w_in(w_in), .a_in(a_in), .sw_in(sw_in),
    .w_out(w_out), .a_out(a_out), .sw_out(sw_out)
  );

  pe_ctrl #(.OPW(OPW)) u_ctrl (
    .en(en), .scan_en(scan_en), .sw_in(sw_in),
    .w_in(w_in), .a_in(a_in),
    .acc_op(acc_op), .rsv_op(rsv_op)
  );

  pe_mac #(.OPW(OPW), .GUARD(GUARD)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_in(sw_in),
    .acc_op(acc_op), .w_in(w_in), .a_in(a_in),
    .rsv_q(rsv_q), .acc_q(acc_q)
  );

  pe_reserve #(.ACCW(ACCW)) u_rsv (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_in(sw_in), .scan_en(scan_en),
    .rsv_op(rsv_op), .scan_in(scan_in), .acc_q(acc_q), .rsv_q(rsv_q)
  );

  assign scan_out = rsv_q;

  // R7: in a swap-and-scan cycle the reserve takes the accumulator, not the scan input
  p_swap_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sw_in && scan_en && (scan_in != acc_q)) |=> (scan_out != $past(scan_in)));
endmodule

// File: tb/test_pe_zg_cell.sv
module test_pe_zg_cell;
  localparam int OPW   = 8;
  localparam int GUARD = 4;
  localparam int ACCW  = 2 * OPW + GUARD;

  typedef struct {
    logic [OPW-1:0]  w;
    logic [OPW-1:0]  a;
    logic            sw;
    logic [ACCW-1:0] so;
    string           req;
  } exp_t;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  en = 1'b0;
  logic                  scan_en = 1'b0;
  logic signed [OPW-1:0] w_in = '0;
  logic signed [OPW-1:0] a_in = '0;
  logic                  sw_in = 1'b0;
  logic [ACCW-1:0]       scan_in = '0;
  logic signed [OPW-1:0] w_out;
  logic signed [OPW-1:0] a_out;
  logic                  sw_out;
  logic [ACCW-1:0]       scan_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // bench-side model of the cell
  logic [ACCW-1:0] m_acc = '0;
  logic [ACCW-1:0] m_rsv = '0;
  logic [OPW-1:0]  m_w = '0;
  logic [OPW-1:0]  m_a = '0;
  logic            m_sw = 1'b0;

  exp_t exp_q[$];
  exp_t item;

  always #10 clk = ~clk;

  pe_zg_cell #(.OPW(OPW), .GUARD(GUARD)) i_pe_zg_cell (
    .clk(clk), .rst_n(rst_n), .en(en), .scan_en(scan_en),
    .w_in(w_in), .a_in(a_in), .sw_in(sw_in), .scan_in(scan_in),
    .w_out(w_out), .a_out(a_out), .sw_out(sw_out), .scan_out(scan_out)
  );

  task automatic step(input logic e, input logic signed [OPW-1:0] w,
                      input logic signed [OPW-1:0] a, input logic s,
                      input logic se, input logic [ACCW-1:0] si, input string req);
    logic [ACCW-1:0] prod;
    logic [ACCW-1:0] n_acc;
    logic [ACCW-1:0] n_rsv;
    exp_t e_item;
    @(negedge clk);
    en = e; w_in = w; a_in = a; sw_in = s; scan_en = se; scan_in = si;
    prod  = ACCW'(int'(w) * int'(a));
    n_acc = m_acc;
    n_rsv = m_rsv;
    if (e) begin
      m_w = w; m_a = a; m_sw = s;
      if (s) begin
        n_acc = m_rsv + prod;
        n_rsv = m_acc;
      end else begin
        if (w != 0 && a != 0) n_acc = m_acc + prod;
        if (se) n_rsv = si;
      end
    end
    m_acc = n_acc;
    m_rsv = n_rsv;
    e_item.w = m_w; e_item.a = m_a; e_item.sw = m_sw; e_item.so = m_rsv; e_item.req = req;
    @(posedge clk);
    #1;
    exp_q.push_back(e_item);
  endtask

  // monitor: compares against the scoreboard away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item = exp_q.pop_front();
      checks++;
      if (w_out !== item.w || a_out !== item.a || sw_out !== item.sw || scan_out !== item.so) begin
        fails++;
        $display("FAIL %s: got w=%0h a=%0h sw=%0b scan=%0h, expected w=%0h a=%0h sw=%0b scan=%0h",
                 item.req, w_out, a_out, sw_out, scan_out, item.w, item.a, item.sw, item.so);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (w_out !== 0 || a_out !== 0 || sw_out !== 0 || scan_out !== 0) begin
      fails++;
      $display("FAIL R1: got w=%0h a=%0h sw=%0b scan=%0h, expected all zero",
               w_out, a_out, sw_out, scan_out);
    end
    rst_n = 1'b1;

    // R1: swapping right after reset drains a zero accumulator
    step(1, 0, 0, 1, 0, 0, "R1");
    // R6: preload through the scan chain
    step(1, 0, 5, 0, 1, 20'd100, "R6");
    // R5: swap the preload in and add 3*4 on top of it
    step(1, 3, 4, 1, 0, 0, "R5");
    // R3 and R9: accumulate while the chain shifts
    step(1, -7, 9, 0, 1, 20'h0ABCD, "R9");
    step(1, 11, -2, 0, 1, 20'h12345, "R3");
    step(1, -128, -128, 0, 0, 0, "R3");
    // R4: zero operands leave the accumulator alone
    step(1, 0, 77, 0, 0, 0, "R4");
    step(1, -5, 0, 0, 0, 0, "R4");
    // R5: drain the sum, with a zero operand in the swap cycle
    step(1, 0, 9, 1, 0, 0, "R5");
    // R7: swap beats scan, so scan_in must not appear
    step(1, 2, 2, 1, 1, 20'h55555, "R7");
    step(1, 0, 0, 1, 0, 0, "R7");
    // R8: stalled cycles with busy inputs
    step(0, 33, 44, 1, 1, 20'h0F0F0, "R8");
    step(0, 1, 1, 0, 1, 20'h00FFF, "R8");
    step(1, 0, 0, 0, 0, 0, "R2");
    // R10: drive the accumulator past its range, then drain it
    for (int i = 0; i < 40; i++) step(1, 127, 127, 0, 0, 0, "R10");
    step(1, 0, 0, 1, 0, 0, "R10");
    for (int i = 0; i < 40; i++) step(1, -128, 127, 0, 0, 0, "R10");
    step(1, 1, 1, 1, 0, 0, "R10");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      logic signed [OPW-1:0] rw;
      logic signed [OPW-1:0] ra;
      rw = ($urandom % 4 == 0) ? '0 : OPW'($urandom);
      ra = ($urandom % 4 == 0) ? '0 : OPW'($urandom);
      step(($urandom % 5) != 0, rw, ra, ($urandom % 6) == 0, $urandom % 2,
           ACCW'($urandom), "R2");
    end
    step(1, 0, 0, 1, 0, 0, "R5");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule